// File: doc/BRIEF.md
# Dual-Clock FIFO with Fall-Through Mode

This block is a first-in first-out buffer whose write port and read port each run on their own free-running clock. The two clocks may be unrelated or may be the same net. A word is accepted on a rising edge of the write clock when the write enable is high. A word is taken on a rising edge of the read clock when the read enable is high. Pointers cross between the two clock domains as Gray-coded values through a chain of synchronizer flops. A status flag observed in the other domain therefore lags the pointer that moved by a few cycles of the observing clock.

The operating mode and two threshold offsets are captured while the master reset is held low, on edges of each port's clock. In standard mode the reader requests every word, including the first one written into an empty buffer. The write-side flag then reports full and the read-side flag reports empty. In fall-through mode the word at the head is presented on the output without a request. The write-side flag then reports that input space is available, and the read-side flag reports that the output holds valid data. Almost-full and almost-empty compare the fill level with the captured offsets. A partial reset flushes the contents and keeps the captured mode and offsets.

Top module: `xclk_fifo`

## Requirements
- R1: Words leave the read port in the order they entered the write port. A write takes place only on a write-clock rising edge with `wr_en` high, and a read only on a read-clock rising edge with `rd_en` high.
- R2: While `mrst_n` is low, both pointers are held at zero, `rd_data` is 0, and on each clock edge the block captures `cfg_ft` (1 = fall-through, 0 = standard), `cfg_ae_off` and `cfg_af_off`. Changes to these inputs while `mrst_n` is high have no effect.
- R3: A write attempted while the buffer holds DEPTH words is ignored. Stored contents and the fill level are unchanged.
- R4: A read attempted while no word is stored is ignored. `rd_data` keeps its value and the next word written is the next one read.
- R5: A low level on `prst_n` empties the buffer and clears `rd_data` to 0, while the captured mode and offsets keep their values.
- R6: In standard mode, a word written into an empty buffer does not appear on `rd_data` until a read request. The word is presented on the read-clock edge that takes the request.
- R7: In fall-through mode, the head word appears on `rd_data` without a request. A read with `rd_data` valid discards it and presents the next stored word, if there is one.
- R8: In standard mode, `full_ir` is 1 exactly when DEPTH words are stored and `empty_or` is 1 exactly when none are stored. In fall-through mode, `full_ir` is 1 when fewer than DEPTH words are stored and `empty_or` is 1 when `rd_data` holds a valid word. Each flag settles within a few cycles of its own clock.
- R9: `almost_empty` (read clock) is 1 when the stored count is at most `cfg_ae_off`. `almost_full` (write clock) is 1 when DEPTH minus the stored count is at most `cfg_af_off`. The stored count includes a word presented in fall-through mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write port clock |
| rd_clk | input | 1 | Read port clock |
| mrst_n | input | 1 | Master reset, active low; empties the buffer and captures configuration |
| prst_n | input | 1 | Partial reset, active low; empties the buffer and keeps configuration |
| cfg_ft | input | 1 | Mode captured at master reset: 1 fall-through, 0 standard |
| cfg_ae_off | input | ADDR_W | Almost-empty offset captured at master reset |
| cfg_af_off | input | ADDR_W | Almost-full offset captured at master reset |
| wr_en | input | 1 | Write enable |
| wr_data | input | DATA_W | Write data |
| full_ir | output | 1 | Full (standard) or input-ready (fall-through), write clock |
| almost_full | output | 1 | Almost-full flag, write clock |
| rd_en | input | 1 | Read enable |
| rd_data | output | DATA_W | Read data |
| empty_or | output | 1 | Empty (standard) or output-ready (fall-through), read clock |
| almost_empty | output | 1 | Almost-empty flag, read clock |

## Verification
The buffer is filled one word at a time from empty to DEPTH and then drained to empty, once in each mode. All four flags are compared at every fill level, which checks both threshold boundaries, the full and empty edges, and the flag polarity swap between modes. Writes into a full buffer and reads from an empty one are followed by reads that would show a skipped or duplicated word. A partial reset is issued after the configuration inputs have been changed to opposite values, which shows whether the mode and offsets were kept rather than reloaded.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;

   typedef enum logic {
      MODE_STD = 1'b0,
      MODE_FT  = 1'b1
   } fifo_mode_e;

   function automatic logic [31:0] to_gray(input logic [31:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [31:0] from_gray(input logic [31:0] g);
      logic [31:0] b;
      b[31] = g[31];
      for (int i = 30; i >= 0; i--) begin
         b[i] = b[i+1] ^ g[i];
      end
      return b;
   endfunction

endpackage

// File: rtl/xfifo_sync.sv
module xfifo_sync #(
   parameter int W      = 7,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= '0;
      end else begin
         stg[0] <= d;
         for (int s = 1; s < STAGES; s++) begin
            stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/xfifo_mem.sv
module xfifo_mem #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 6
) (
   input  logic              wclk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) begin
         cells[waddr] <= wdata;
      end
   end

   assign rdata = cells[raddr];

endmodule

// File: rtl/xfifo_wr_ctl.sv
module xfifo_wr_ctl
   import xfifo_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mrst_n,
   input  logic              cfg_ft,
   input  logic [ADDR_W-1:0] cfg_af_off,
   input  logic              wr_en,
   input  logic [ADDR_W:0]   rgray_s,
   output logic [ADDR_W:0]   wgray,
   output logic [ADDR_W-1:0] waddr,
   output logic              wr_fire,
   output logic              full_ir,
   output logic              almost_full
);

   localparam int PW = ADDR_W + 1;
   localparam logic [PW-1:0] DEPTH_P = PW'(1 << ADDR_W);

   fifo_mode_e        mode_q;
   logic [ADDR_W-1:0] af_q;
   logic [PW-1:0]     wptr;
   logic [PW-1:0]     rptr_b;
   logic [PW-1:0]     used;
   logic [PW-1:0]     room;
   logic              full;

   // configuration is captured only while master reset is held
   always_ff @(posedge clk) begin
      if (!mrst_n) begin
         mode_q <= fifo_mode_e'(cfg_ft);
         af_q   <= cfg_af_off;
      end
   end

   assign rptr_b  = PW'(from_gray(32'(rgray_s)));
   assign used    = wptr - rptr_b;
   assign full    = (used == DEPTH_P);
   assign room    = DEPTH_P - used;
   assign wr_fire = wr_en & ~full;
   assign waddr   = wptr[ADDR_W-1:0];

   assign full_ir     = (mode_q == MODE_FT) ? ~full : full;
   assign almost_full = (room <= {1'b0, af_q});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         wgray <= '0;
      end else if (wr_fire) begin
         wptr  <= wptr + 1'b1;
         wgray <= PW'(to_gray(32'(wptr + 1'b1)));
      end
   end

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr_en) |=> $stable(wptr));

   p_write_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !full) |=> (wptr == $past(wptr) + 1'b1));

   p_used_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      used <= DEPTH_P);

   p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!mrst_n)
      $past(mrst_n) |-> ($stable(mode_q) && $stable(af_q)));

endmodule

// File: rtl/xfifo_rd_ctl.sv
module xfifo_rd_ctl
   import xfifo_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mrst_n,
   input  logic              cfg_ft,
   input  logic [ADDR_W-1:0] cfg_ae_off,
   input  logic              rd_en,
   input  logic [ADDR_W:0]   wgray_s,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] raddr,
   output logic [ADDR_W:0]   rgray,
   output logic [DATA_W-1:0] rd_data,
   output logic              empty_or,
   output logic              almost_empty
);

   localparam int PW = ADDR_W + 1;
   localparam logic [PW-1:0] DEPTH_P = PW'(1 << ADDR_W);

   fifo_mode_e        mode_q;
   logic [ADDR_W-1:0] ae_q;
   logic [PW-1:0]     rptr;
   logic [PW-1:0]     wptr_b;
   logic [PW-1:0]     avail;
   logic              empty;
   logic              out_valid;
   logic              take_std;
   logic              consume_ft;
   logic              adv;

   always_ff @(posedge clk) begin
      if (!mrst_n) begin
         mode_q <= fifo_mode_e'(cfg_ft);
         ae_q   <= cfg_ae_off;
      end
   end

   assign wptr_b     = PW'(from_gray(32'(wgray_s)));
   assign avail      = wptr_b - rptr;
   assign empty      = (avail == '0);
   assign take_std   = (mode_q == MODE_STD) & rd_en & ~empty;
   assign consume_ft = (mode_q == MODE_FT) & rd_en & out_valid;
   assign adv        = take_std | consume_ft;
   // on a fall-through consume, look one slot ahead for the next head word
   assign raddr      = consume_ft ? (rptr[ADDR_W-1:0] + 1'b1) : rptr[ADDR_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr  <= '0;
         rgray <= '0;
      end else if (adv) begin
         rptr  <= rptr + 1'b1;
         rgray <= PW'(to_gray(32'(rptr + 1'b1)));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data   <= '0;
         out_valid <= 1'b0;
      end else if (mode_q == MODE_STD) begin
         out_valid <= 1'b0;
         if (take_std) begin
            rd_data <= mem_rdata;
         end
      end else if (consume_ft) begin
         if (avail > PW'(1)) begin
            rd_data   <= mem_rdata;
            out_valid <= 1'b1;
         end else begin
            out_valid <= 1'b0;
         end
      end else if (!out_valid && !empty) begin
         rd_data   <= mem_rdata;
         out_valid <= 1'b1;
      end
   end

   assign empty_or     = (mode_q == MODE_FT) ? out_valid : empty;
   assign almost_empty = (avail <= {1'b0, ae_q});

   p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && rd_en) |=> $stable(rptr));

   p_valid_has_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !empty);

   p_ft_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q == MODE_FT) && !out_valid && !empty) |=> out_valid);

   p_std_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q == MODE_STD) && !rd_en) |=> $stable(rd_data));

   p_avail_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      avail <= DEPTH_P);

   p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!mrst_n)
      $past(mrst_n) |-> ($stable(mode_q) && $stable(ae_q)));

endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo #(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic              wr_clk,
   input  logic              rd_clk,
   input  logic              mrst_n,
   input  logic              prst_n,
   input  logic              cfg_ft,
   input  logic [ADDR_W-1:0] cfg_ae_off,
   input  logic [ADDR_W-1:0] cfg_af_off,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              full_ir,
   output logic              almost_full,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              empty_or,
   output logic              almost_empty
);

   localparam int PW = ADDR_W + 1;

   if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_addr
      $error("xclk_fifo: ADDR_W must lie in 2..16");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("xclk_fifo: DATA_W must be positive");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("xclk_fifo: SYNC_STAGES must be at least 2");
   end

   logic              rst_n;
   logic [PW-1:0]     wgray;
   logic [PW-1:0]     rgray;
   logic [PW-1:0]     wgray_s;
   logic [PW-1:0]     rgray_s;
   logic [ADDR_W-1:0] waddr;
   logic [ADDR_W-1:0] raddr;
   logic              wr_fire;
   logic [DATA_W-1:0] mem_rdata;

   assign rst_n = mrst_n & prst_n;

   xfifo_wr_ctl #(.ADDR_W(ADDR_W)) wr_ctl_i (
      .clk         (wr_clk),
      .rst_n       (rst_n),
      .mrst_n      (mrst_n),
      .cfg_ft      (cfg_ft),
      .cfg_af_off  (cfg_af_off),
      .wr_en       (wr_en),
      .rgray_s     (rgray_s),
      .wgray       (wgray),
      .waddr       (waddr),
      .wr_fire     (wr_fire),
      .full_ir     (full_ir),
      .almost_full (almost_full)
   );

   xfifo_rd_ctl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) rd_ctl_i (
      .clk          (rd_clk),
      .rst_n        (rst_n),
      .mrst_n       (mrst_n),
      .cfg_ft       (cfg_ft),
      .cfg_ae_off   (cfg_ae_off),
      .rd_en        (rd_en),
      .wgray_s      (wgray_s),
      .mem_rdata    (mem_rdata),
      .raddr        (raddr),
      .rgray        (rgray),
      .rd_data      (rd_data),
      .empty_or     (empty_or),
      .almost_empty (almost_empty)
   );

   xfifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) mem_i (
      .wclk  (wr_clk),
      .we    (wr_fire),
      .waddr (waddr),
      .wdata (wr_data),
      .raddr (raddr),
      .rdata (mem_rdata)
   );

   xfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) w2r_sync_i (
      .clk   (rd_clk),
      .rst_n (rst_n),
      .d     (wgray),
      .q     (wgray_s)
   );

   xfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) r2w_sync_i (
      .clk   (wr_clk),
      .rst_n (rst_n),
      .d     (rgray),
      .q     (rgray_s)
   );

   p_gray_step_r1: assert property (@(posedge wr_clk) disable iff (!rst_n)
      $countones(wgray ^ $past(wgray)) <= 1);

endmodule

// File: tb/xclk_fifo_tb_top.sv
module xclk_fifo_tb_top;

   localparam int DW    = 8;
   localparam int AW    = 6;
   localparam int DEPTH = 1 << AW;

   logic          wr_clk = 1'b0;
   logic          rd_clk = 1'b0;
   logic          mrst_n = 1'b0;
   logic          prst_n = 1'b1;
   logic          cfg_ft = 1'b0;
   logic [AW-1:0] cfg_ae_off = '0;
   logic [AW-1:0] cfg_af_off = '0;
   logic          wr_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          rd_en = 1'b0;
   logic          full_ir;
   logic          almost_full;
   logic [DW-1:0] rd_data;
   logic          empty_or;
   logic          almost_empty;

   int n_cmp = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #10 wr_clk = ~wr_clk;
   initial begin
      #7;
      forever #10 rd_clk = ~rd_clk;
   end

   xclk_fifo #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(2)) dut_i (
      .wr_clk       (wr_clk),
      .rd_clk       (rd_clk),
      .mrst_n       (mrst_n),
      .prst_n       (prst_n),
      .cfg_ft       (cfg_ft),
      .cfg_ae_off   (cfg_ae_off),
      .cfg_af_off   (cfg_af_off),
      .wr_en        (wr_en),
      .wr_data      (wr_data),
      .full_ir      (full_ir),
      .almost_full  (almost_full),
      .rd_en        (rd_en),
      .rd_data      (rd_data),
      .empty_or     (empty_or),
      .almost_empty (almost_empty)
   );

   function automatic logic [DW-1:0] pat(input int i);
      return DW'((i * 37 + 5) & 255);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic settle();
      repeat (6) @(posedge wr_clk);
      repeat (6) @(posedge rd_clk);
      #5;
   endtask

   task automatic push(input logic [DW-1:0] v);
      @(negedge wr_clk);
      wr_en   = 1'b1;
      wr_data = v;
      @(negedge wr_clk);
      wr_en   = 1'b0;
   endtask

   task automatic pop();
      @(negedge rd_clk);
      rd_en = 1'b1;
      @(negedge rd_clk);
      rd_en = 1'b0;
   endtask

   task automatic flags(input bit ft, input int n, input int ae, input int af);
      chk("R8 full_ir", 32'(full_ir), ft ? 32'(n < DEPTH) : 32'(n == DEPTH));
      chk("R8 empty_or", 32'(empty_or), ft ? 32'(n > 0) : 32'(n == 0));
      chk("R9 almost_empty", 32'(almost_empty), 32'(n <= ae));
      chk("R9 almost_full", 32'(almost_full), 32'((DEPTH - n) <= af));
   endtask

   task automatic master_reset(input bit ft, input int ae, input int af);
      @(negedge wr_clk);
      mrst_n     = 1'b0;
      cfg_ft     = ft;
      cfg_ae_off = AW'(ae);
      cfg_af_off = AW'(af);
      repeat (4) @(posedge wr_clk);
      repeat (4) @(posedge rd_clk);
      @(negedge wr_clk);
      mrst_n     = 1'b1;
      // opposite values after release must not be taken (R2)
      cfg_ft     = ~ft;
      cfg_ae_off = AW'(20);
      cfg_af_off = AW'(20);
      settle();
   endtask

   task automatic partial_reset();
      @(negedge wr_clk);
      prst_n = 1'b0;
      repeat (3) @(posedge wr_clk);
      repeat (3) @(posedge rd_clk);
      @(negedge wr_clk);
      prst_n = 1'b1;
      settle();
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_cmp++;
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
         $finish;
      end
   end

   initial begin
      // ---------- standard mode, offsets 4 / 4 ----------
      master_reset(1'b0, 4, 4);
      chk("R2 reset rd_data", 32'(rd_data), 32'h0);
      flags(1'b0, 0, 4, 4);

      for (int n = 1; n <= DEPTH; n++) begin
         push(pat(n - 1));
         settle();
         flags(1'b0, n, 4, 4);
         if (n == 1) chk("R6 no fall-through in standard", 32'(rd_data), 32'h0);
      end

      push(pat(150));
      settle();
      flags(1'b0, DEPTH, 4, 4);  // R3 write at full ignored

      for (int k = 0; k < DEPTH; k++) begin
         pop();
         settle();
         chk("R1 R3 standard order", 32'(rd_data), 32'(pat(k)));
         flags(1'b0, DEPTH - 1 - k, 4, 4);
      end

      pop();
      settle();
      chk("R4 read at empty holds data", 32'(rd_data), 32'(pat(DEPTH - 1)));
      flags(1'b0, 0, 4, 4);
      push(pat(100));
      settle();
      chk("R6 word waits for request", 32'(rd_data), 32'(pat(DEPTH - 1)));
      pop();
      settle();
      chk("R4 no skipped word", 32'(rd_data), 32'(pat(100)));

      // ---------- partial reset keeps configuration ----------
      for (int i = 0; i < 10; i++) push(pat(110 + i));
      partial_reset();
      chk("R5 rd_data cleared", 32'(rd_data), 32'h0);
      flags(1'b0, 0, 4, 4);
      for (int i = 0; i < 5; i++) push(pat(120 + i));
      settle();
      chk("R5 mode kept standard", 32'(rd_data), 32'h0);
      chk("R5 ae offset kept", 32'(almost_empty), 32'h0);
      flags(1'b0, 5, 4, 4);
      for (int i = 0; i < 5; i++) begin
         pop();
         settle();
         chk("R5 R1 data after flush", 32'(rd_data), 32'(pat(120 + i)));
      end

      // ---------- fall-through mode, offsets 8 / 16 ----------
      master_reset(1'b1, 8, 16);
      chk("R2 reset rd_data", 32'(rd_data), 32'h0);
      flags(1'b1, 0, 8, 16);

      for (int n = 1; n <= DEPTH; n++) begin
         push(pat(70 + n - 1));
         settle();
         flags(1'b1, n, 8, 16);
         chk("R7 head word shown", 32'(rd_data), 32'(pat(70)));
      end

      push(pat(150));
      settle();
      flags(1'b1, DEPTH, 8, 16);  // R3 write with input-ready low ignored

      for (int k = 0; k < DEPTH; k++) begin
         chk("R7 R1 fall-through order", 32'(rd_data), 32'(pat(70 + k)));
         pop();
         settle();
         flags(1'b1, DEPTH - 1 - k, 8, 16);
      end

      pop();
      settle();
      flags(1'b1, 0, 8, 16);  // R4 read with nothing valid
      push(pat(30));
      settle();
      chk("R4 R7 next word after empty read", 32'(rd_data), 32'(pat(30)));
      flags(1'b1, 1, 8, 16);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
   end

endmodule